// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the single reservation that pairs a load-reserve with a later store-conditional, sitting beside a data cache. A load-reserve records that a reservation is held and which cache line it covers. No access length is kept. A later store-conditional is compared against that record. When it matches, the store is let through to the cache. When it does not, the write is cancelled, so no cache write and no bus cycle happen, and the operation completes at once with a failure report. Both outcomes drop the reservation.

Every store-conditional completes one cycle after it is presented. The completion asks writeback to update CR0 with a nibble whose equal bit holds the success flag and whose last bit copies the summary-overflow input. Plain stores pass through with no condition-register update. A separate clear input lets a snooped write or an interrupt throw the reservation away. All outputs are registered.

Top module: `atomic_resv_tracker`

## Requirements
- R1: After a synchronous reset, `resv_held`, `st_wr`, `st_cancel`, `cmp_done`, `cmp_rc`, `cmp_stored` and `cr0_out` are all 0.
- R2: `req_op` is encoded as 00 = other access (no effect), 01 = load-reserve, 10 = store-conditional, 11 = plain store. A load-reserve with `req_valid`=1 sets `resv_held` at the next edge and records the line address `req_addr[ADDR_W-1:log2(LINE_BYTES)]`. It produces no completion pulse.
- R3: Success case. A store-conditional whose line matches a held reservation (offset bits are ignored) gives, one cycle later, `st_wr`=1, `st_cancel`=0, `cmp_done`=1, `cmp_rc`=1 and `cmp_stored`=1.
- R4: Failure case. A store-conditional with no reservation held, or with a different line, gives, one cycle later, `st_wr`=0, `st_cancel`=1, `cmp_done`=1, `cmp_rc`=1 and `cmp_stored`=0.
- R5: Every store-conditional clears `resv_held` at the next edge, whether it succeeds or fails. A second store-conditional therefore fails.
- R6: `cr0_out` is valid while `cmp_rc`=1. Bit 3 and bit 2 are 0, bit 1 equals `cmp_stored`, and bit 0 equals the `so_in` value sampled with the store-conditional.
- R7: `kill_resv`=1 clears `resv_held` at the next edge. It wins over a load-reserve presented in the same cycle. It forces a store-conditional presented in the same cycle to fail.
- R8: A plain store gives, one cycle later, `st_wr`=1, `st_cancel`=0, `cmp_done`=1, `cmp_rc`=0, `cmp_stored`=0 and `cr0_out`=0. It leaves the reservation unchanged.
- R9: With `req_valid`=0, `req_op` and `req_addr` are ignored. No output pulses and the reservation is unchanged.
- R10: A new load-reserve replaces the recorded line. A store-conditional to the old line then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Access class (see R2) |
| req_addr | input | ADDR_W | Byte address of the access |
| so_in | input | 1 | Summary-overflow bit to copy into CR0 |
| kill_resv | input | 1 | Drop the reservation (snoop hit or interrupt) |
| st_wr | output | 1 | Store allowed to write the cache |
| st_cancel | output | 1 | Store-conditional write cancelled, no bus cycle |
| cmp_done | output | 1 | Store completion pulse |
| cmp_rc | output | 1 | Completion requests a CR0 update |
| cmp_stored | output | 1 | Store-conditional performed its store |
| cr0_out | output | 4 | CR0 value for writeback |
| resv_held | output | 1 | Reservation currently held |

## Verification
The bench builds the block with ADDR_W=32 and LINE_BYTES=16, so the line offset is four bits wide. With that setting, an address at the far end of a line, the first byte of the neighbouring line and a change in the top address bit are all easy to reach. This lets the bench show that offset bits are ignored while every tag bit, up to the most significant one, takes part in the match.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LRSV  = 2'b01,
    OP_SCND  = 2'b10,
    OP_STORE = 2'b11
  } mem_op_e;

  typedef struct packed {
    logic       wr_go;
    logic       cancel;
    logic       done;
    logic       rc;
    logic       stored;
    logic [3:0] cr0;
  } resp_t;
endpackage

// File: rtl/resv_line_match.sv
module resv_line_match #(
  parameter int TAG_W = 58
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             equal
);
  logic [TAG_W-1:0] bit_eq;

  genvar gi;
  generate
    for (gi = 0; gi < TAG_W; gi++) begin : g_bit
      assign bit_eq[gi] = ~(tag_a[gi] ^ tag_b[gi]);
    end
  endgenerate

  assign equal = &bit_eq;
endmodule

// File: rtl/resv_holder.sv
module resv_holder #(
  parameter int TAG_W = 58
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic             held,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      tag  <= '0;
    end else if (clr_en) begin
      held <= 1'b0;
    end else if (set_en) begin
      held <= 1'b1;
      tag  <= set_tag;
    end
  end

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !held); // R5
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> (held && tag == $past(set_tag))); // R2
  AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> ($stable(held) && $stable(tag))); // R9
endmodule

// File: rtl/resv_resp_regs.sv
module resv_resp_regs
  import resv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire_sc,
  input  logic  fire_st,
  input  logic  sc_ok,
  input  logic  so_in,
  output resp_t resp
);
  resp_t nxt;

  always_comb begin
    nxt = '0;
    if (fire_sc) begin
      nxt.wr_go  = sc_ok;
      nxt.cancel = ~sc_ok;
      nxt.done   = 1'b1;
      nxt.rc     = 1'b1;
      nxt.stored = sc_ok;
      nxt.cr0    = {2'b00, sc_ok, so_in};
    end else if (fire_st) begin
      nxt.wr_go  = 1'b1;
      nxt.done   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) resp <= '0;
    else     resp <= nxt;
  end

  AST_NO_DUAL_PATH: assert property (@(posedge clk) disable iff (rst)
    !(resp.wr_go && resp.cancel)); // R4
  AST_CANCEL_FAILS: assert property (@(posedge clk) disable iff (rst)
    resp.cancel |-> (resp.done && resp.rc && !resp.stored)); // R4
  AST_CR0_SHAPE: assert property (@(posedge clk) disable iff (rst)
    resp.rc |-> (resp.cr0[3:2] == 2'b00 && resp.cr0[1] == resp.stored)); // R6
endmodule

// File: rtl/atomic_resv_tracker.sv
module atomic_resv_tracker
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              so_in,
  input  logic              kill_resv,
  output logic              st_wr,
  output logic              st_cancel,
  output logic              cmp_done,
  output logic              cmp_rc,
  output logic              cmp_stored,
  output logic [3:0]        cr0_out,
  output logic              resv_held
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int TAG_W    = ADDR_W - LINE_LSB;

  mem_op_e          op;
  logic             is_lr, is_sc, is_st;
  logic [TAG_W-1:0] req_tag, held_tag;
  logic             tag_eq, sc_ok;
  resp_t            resp;

  assign op      = mem_op_e'(req_op);
  assign is_lr   = req_valid && (op == OP_LRSV);
  assign is_sc   = req_valid && (op == OP_SCND);
  assign is_st   = req_valid && (op == OP_STORE);
  assign req_tag = req_addr[ADDR_W-1:LINE_LSB];

  resv_line_match #(.TAG_W(TAG_W)) u_match (
    .tag_a (req_tag),
    .tag_b (held_tag),
    .equal (tag_eq)
  );

  resv_holder #(.TAG_W(TAG_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .set_en  (is_lr),
    .clr_en  (kill_resv | is_sc),
    .set_tag (req_tag),
    .held    (resv_held),
    .tag     (held_tag)
  );

  assign sc_ok = is_sc && resv_held && tag_eq && !kill_resv;

  resv_resp_regs u_resp (
    .clk     (clk),
    .rst     (rst),
    .fire_sc (is_sc),
    .fire_st (is_st),
    .sc_ok   (sc_ok),
    .so_in   (so_in),
    .resp    (resp)
  );

  assign st_wr      = resp.wr_go;
  assign st_cancel  = resp.cancel;
  assign cmp_done   = resp.done;
  assign cmp_rc     = resp.rc;
  assign cmp_stored = resp.stored;
  assign cr0_out    = resp.cr0;

  AST_KILL_DROPS: assert property (@(posedge clk) disable iff (rst)
    kill_resv |=> (!resv_held && !st_wr || !cmp_rc)); // R7
  AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !resv_held) |=> st_cancel); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !cmp_done); // R9
endmodule

// File: tb/atomic_resv_tracker_test.sv
module atomic_resv_tracker_test;
  localparam int AW = 32;
  localparam int LB = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic          so_in;
  logic          kill_resv;
  logic          st_wr, st_cancel, cmp_done, cmp_rc, cmp_stored, resv_held;
  logic [3:0]    cr0_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  atomic_resv_tracker #(.ADDR_W(AW), .LINE_BYTES(LB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .so_in(so_in), .kill_resv(kill_resv),
    .st_wr(st_wr), .st_cancel(st_cancel), .cmp_done(cmp_done),
    .cmp_rc(cmp_rc), .cmp_stored(cmp_stored), .cr0_out(cr0_out),
    .resv_held(resv_held)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs packed as {st_wr, st_cancel, cmp_done, cmp_rc, cmp_stored, cr0_out}
  function automatic logic [8:0] outs();
    return {st_wr, st_cancel, cmp_done, cmp_rc, cmp_stored, cr0_out};
  endfunction

  // present one request for one cycle; sample one edge later
  task automatic issue(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic so, input logic kill);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; so_in = so; kill_resv = kill;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00; so_in = 1'b0; kill_resv = 1'b0;
  endtask

  localparam logic [1:0] LR = 2'b01, SC = 2'b10, ST = 2'b11;
  localparam logic [8:0] SC_OK   = 9'b10111_0010;
  localparam logic [8:0] SC_BAD  = 9'b01110_0000;
  localparam logic [8:0] QUIET   = 9'b0;
  localparam logic [8:0] ST_DONE = 9'b10100_0000;

  task automatic t_reset();
    check("R1 outputs", {23'd0, outs()}, 32'd0);
    check("R1 held", resv_held, 0);
  endtask

  task automatic t_hit_offset();
    issue(1, LR, 32'h0000_1230, 0, 0);
    check("R2 held", resv_held, 1);
    check("R2 no completion", cmp_done, 0);
    issue(1, SC, 32'h0000_123F, 0, 0);
    check("R3 success", outs(), SC_OK);
    check("R5 cleared after success", resv_held, 0);
  endtask

  task automatic t_no_resv();
    issue(1, SC, 32'h0000_1230, 0, 0);
    check("R4 no reservation", outs(), SC_BAD);
  endtask

  task automatic t_neighbour();
    issue(1, LR, 32'h0000_2000, 0, 0);
    issue(1, SC, 32'h0000_2010, 0, 0);
    check("R4 neighbour line", outs(), SC_BAD);
    check("R5 cleared after failure", resv_held, 0);
    issue(1, LR, 32'h0000_2000, 0, 0);
    issue(1, SC, 32'h8000_2000, 0, 0);
    check("R4 top bit differs", outs(), SC_BAD);
  endtask

  task automatic t_second_sc();
    issue(1, LR, 32'h0000_3000, 0, 0);
    issue(1, SC, 32'h0000_3000, 0, 0);
    check("R5 first sc", cmp_stored, 1);
    issue(1, SC, 32'h0000_3000, 0, 0);
    check("R5 second sc fails", outs(), SC_BAD);
  endtask

  task automatic t_so_copy();
    issue(1, LR, 32'h0000_4000, 0, 0);
    issue(1, SC, 32'h0000_4004, 1, 0);
    check("R6 cr0 success with so", cr0_out, 4'b0011);
    issue(1, SC, 32'h0000_4004, 1, 0);
    check("R6 cr0 fail with so", cr0_out, 4'b0001);
  endtask

  task automatic t_kill();
    issue(1, LR, 32'h0000_5000, 0, 0);
    issue(0, 2'b00, 32'h0, 0, 1);
    check("R7 kill clears", resv_held, 0);
    issue(1, SC, 32'h0000_5000, 0, 0);
    check("R7 sc after kill", outs(), SC_BAD);
    issue(1, LR, 32'h0000_5000, 0, 1);
    check("R7 kill beats lr", resv_held, 0);
    issue(1, LR, 32'h0000_5000, 0, 0);
    issue(1, SC, 32'h0000_5000, 0, 1);
    check("R7 kill with sc", outs(), SC_BAD);
  endtask

  task automatic t_plain();
    issue(1, LR, 32'h0000_6000, 0, 0);
    issue(1, ST, 32'h0000_6000, 1, 0);
    check("R8 plain store", outs(), ST_DONE);
    check("R8 resv kept", resv_held, 1);
    issue(1, SC, 32'h0000_6008, 0, 0);
    check("R8 sc still hits", outs(), SC_OK);
  endtask

  task automatic t_idle();
    issue(1, LR, 32'h0000_7000, 0, 0);
    issue(0, SC, 32'h0000_7000, 0, 0);
    check("R9 invalid sc silent", outs(), QUIET);
    check("R9 resv kept", resv_held, 1);
    issue(0, LR, 32'h0000_9000, 0, 0);
    issue(1, SC, 32'h0000_7000, 0, 0);
    check("R9 invalid lr ignored", outs(), SC_OK);
    issue(1, 2'b00, 32'h0000_7000, 0, 0);
    check("R2 other op no effect", outs(), QUIET);
  endtask

  task automatic t_replace();
    issue(1, LR, 32'h0000_8000, 0, 0);
    issue(1, LR, 32'h0000_8100, 0, 0);
    issue(1, SC, 32'h0000_8000, 0, 0);
    check("R10 old line fails", outs(), SC_BAD);
    issue(1, LR, 32'h0000_8000, 0, 0);
    issue(1, LR, 32'h0000_8100, 0, 0);
    issue(1, SC, 32'h0000_810C, 0, 0);
    check("R10 new line hits", outs(), SC_OK);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_op = 0; req_addr = 0; so_in = 0; kill_resv = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hit_offset();
    t_no_resv();
    t_neighbour();
    t_second_sc();
    t_so_copy();
    t_kill();
    t_plain();
    t_idle();
    t_replace();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule